// File: doc/BRIEF.md
# NAND Command-Word Cycle Sequencer

This block turns 32-bit command words into operations on a parallel NAND flash bus. Software or a bus bridge pushes words into a small queue. The sequencer takes them one at a time and performs the operation each word asks for:

- an address cycle, with the address-latch pin high;
- a command cycle, with the command-latch pin high;
- a data write burst;
- a data read burst.

Each strobe on the flash bus is one clock low followed by at least one clock high. The word chooses one of four cycle kinds. It can ask the sequencer to hold completion until the flash reports ready, to mark the end of a sequence, or to raise an interrupt on completion. For address and command cycles the word carries the bus byte. For data bursts it carries the byte count minus one.

Data bytes come from, and go to, the memory side over a simple byte interface. Writing uses `wr_data` and `wr_take`. Reading uses `rd_data` and `rd_valid`. A data word that is taken from the queue while the memory side is not ready is discarded and flagged as an error. A push into a full queue is also discarded and flagged as an error.

Top module: `nand_seq`

## Requirements
- R1: While reset is applied, and after it is released with no word pushed, the outputs are idle. WE# and RE# are high. ALE, CLE, the I/O output enable, cmd_done, cmd_err, cmd_irq and seq_last are all low.
- R2: A word with type bits [17:16] = 0 produces one WE# low pulse. During that pulse ALE is high, CLE is low, the output enable is high, and the I/O bus carries word bits [7:0].
- R3: A word with type bits [17:16] = 1 produces one WE# low pulse. During that pulse CLE is high, ALE is low, and the I/O bus carries word bits [7:0]. ALE and CLE are never high together.
- R4: A word with type = 2 and count field bits [11:0] = N produces N+1 WE# pulses, with ALE and CLE low. Each pulse drives the current `wr_data` byte and asserts `wr_take`, so the bytes go out in the order the memory side supplies them.
- R5: A word with type = 3 and count N produces N+1 RE# pulses with the output enable low. After each pulse, `rd_valid` is high for one cycle and `rd_data` holds the I/O input sampled on the clock edge that ends that pulse.
- R6: When bit 19 (wait-for-ready) is set, cmd_done is held back for as long as R/B# is low. It rises one cycle after R/B# is seen high.
- R7: cmd_done is a one-cycle pulse for each completed word. For a word of B bus bytes pushed into an idle block, cmd_done is high 2B+1 cycles after the push edge without wait-for-ready. With wait-for-ready and R/B# already high, it is high 2B+2 cycles after the push edge.
- R8: cmd_irq pulses together with cmd_done only for words with bit 13 set.
- R9: seq_last pulses together with cmd_done only for words with bit 18 set.
- R10: The queue holds 4 words and executes them in push order. A push while it is full is dropped, and cmd_err is high in the cycle right after that push edge.
- R11: A data word (type 2 or 3) taken from the queue while `dma_ready` is low produces no strobe and no cmd_done. It raises cmd_err for one cycle.
- R12: WE# and RE# are never low together. Each low strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_push | input | 1 | Push `cmd_word` into the queue |
| cmd_word | input | 32 | Command word |
| dma_ready | input | 1 | Memory side can serve a data burst |
| wr_data | input | 8 | Next byte to write to the flash |
| wr_take | output | 1 | `wr_data` is consumed in this cycle |
| rd_data | output | 8 | Byte read from the flash |
| rd_valid | output | 1 | `rd_data` is valid in this cycle |
| nand_ale | output | 1 | Address latch enable |
| nand_cle | output | 1 | Command latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus value driven to the flash |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus value from the flash |
| nand_rb_n | input | 1 | Ready/busy from the flash, low while busy (synchronous) |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle error pulse (queue overflow or memory side not ready) |
| cmd_irq | output | 1 | Completion pulse for words that request an interrupt |
| seq_last | output | 1 | Completion pulse for words that mark the end of a sequence |

## Verification
A word pushed into an empty, idle block leaves the queue on the next edge. Its first strobe follows one cycle after that, and each further bus byte adds two cycles. cmd_done is therefore due 2B+1 edges after the push edge, or one edge later when wait-for-ready is set. The bench counts edges from the push and compares this count with the exact figure.

Overflow errors appear in the cycle after the rejected push edge, and the bench samples them there. A release of R/B# must produce completion on the very next edge.

Strobes, read bytes and completion pulses are logged half a cycle after each edge. The scenario checks then compare the logs with bytes and orders computed from the words that were pushed.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // Cycle kind carried in the command word
  typedef enum logic [1:0] {
    CYC_ADDR = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_WR   = 2'd2,
    CYC_RD   = 2'd3
  } cyc_kind_t;

  // Field positions inside a command word
  localparam int TYPE_LSB = 16;
  localparam int WAIT_BIT = 19;
  localparam int LAST_BIT = 18;
  localparam int IRQ_BIT  = 13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_RECOVER,
    ST_WAIT_RB,
    ST_FINISH
  } seq_state_t;

endpackage

// File: rtl/nand_seq_fifo.sv
module nand_seq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  always_comb begin
    empty    = (cnt_q == '0);
    full     = (cnt_q == CW'(DEPTH));
    push_ok  = push && !full;
    pop_ok   = pop && !empty;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    head = slot_q[rd_ptr_q];
  end

  // One storage register per entry, each with its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wr_ptr_q == AW'(g))) slot_q[g] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] head,
  input  logic              empty,
  output logic              pop,
  output logic              dma_err,
  input  logic              dma_ready,
  input  logic              rb_n,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic [7:0]        io_in,
  output logic              ale,
  output logic              cle,
  output logic              we_n,
  output logic              re_n,
  output logic [7:0]        io_out,
  output logic              io_oe,
  output logic              done,
  output logic              irq,
  output logic              last
);
  seq_state_t       state_q, state_d;
  cyc_kind_t        kind_q, kind_d, head_kind;
  logic             wait_q, wait_d, last_q, last_d, irq_q, irq_d;
  logic [7:0]       byte_q, byte_d, rd_q;
  logic [CNT_W-1:0] left_q, left_d;
  logic             head_is_data, load_en, cap_en, on_bus;

  // Decode of the queue head and next-state logic
  always_comb begin
    head_kind    = cyc_kind_t'(head[TYPE_LSB+1:TYPE_LSB]);
    head_is_data = (head_kind == CYC_WR) || (head_kind == CYC_RD);
    pop          = (state_q == ST_IDLE) && !empty;
    dma_err      = pop && head_is_data && !dma_ready;
    load_en      = pop && !dma_err;
    cap_en       = (state_q == ST_STROBE) && (kind_q == CYC_RD);
    state_d = state_q;
    kind_d  = kind_q;
    wait_d  = wait_q;
    last_d  = last_q;
    irq_d   = irq_q;
    byte_d  = byte_q;
    left_d  = left_q;
    case (state_q)
      ST_IDLE: begin
        if (load_en) begin
          state_d = ST_STROBE;
          kind_d  = head_kind;
          wait_d  = head[WAIT_BIT];
          last_d  = head[LAST_BIT];
          irq_d   = head[IRQ_BIT];
          byte_d  = head[7:0];
          left_d  = head_is_data ? head[CNT_W-1:0] : '0;
        end
      end
      ST_STROBE:  state_d = ST_RECOVER;
      ST_RECOVER: begin
        if (left_q != '0) begin
          left_d  = left_q - 1'b1;
          state_d = ST_STROBE;
        end else begin
          state_d = wait_q ? ST_WAIT_RB : ST_FINISH;
        end
      end
      ST_WAIT_RB: if (rb_n) state_d = ST_FINISH;
      ST_FINISH:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // Pin drive derived from the registered state
  always_comb begin
    on_bus   = (state_q == ST_STROBE) || (state_q == ST_RECOVER);
    ale      = on_bus && (kind_q == CYC_ADDR);
    cle      = on_bus && (kind_q == CYC_CMD);
    io_oe    = on_bus && (kind_q != CYC_RD);
    we_n     = !((state_q == ST_STROBE) && (kind_q != CYC_RD));
    re_n     = !((state_q == ST_STROBE) && (kind_q == CYC_RD));
    io_out   = (kind_q == CYC_WR) ? wr_data : byte_q;
    wr_take  = (state_q == ST_STROBE) && (kind_q == CYC_WR);
    rd_valid = (state_q == ST_RECOVER) && (kind_q == CYC_RD);
    rd_data  = rd_q;
    done     = (state_q == ST_FINISH);
    irq      = done && irq_q;
    last     = done && last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= CYC_ADDR;
      wait_q  <= 1'b0;
      last_q  <= 1'b0;
      irq_q   <= 1'b0;
      byte_q  <= '0;
      left_q  <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      if (load_en) begin
        kind_q <= kind_d;
        wait_q <= wait_d;
        last_q <= last_d;
        irq_q  <= irq_d;
        byte_q <= byte_d;
      end
      left_q <= left_d;
      if (cap_en) rd_q <= io_in;
    end
  end

endmodule

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_push,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              dma_ready,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  input  logic              nand_rb_n,
  output logic              cmd_done,
  output logic              cmd_err,
  output logic              cmd_irq,
  output logic              seq_last
);
  logic              rst_meta_q, rst_sync_q;
  logic [WORD_W-1:0] head;
  logic              empty, full, pop, dma_err;
  logic              err_q, err_d;

  // Reset asserts at once and is released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  nand_seq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .push  (cmd_push),
    .din   (cmd_word),
    .pop   (pop),
    .head  (head),
    .empty (empty),
    .full  (full)
  );

  nand_seq_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .head      (head),
    .empty     (empty),
    .pop       (pop),
    .dma_err   (dma_err),
    .dma_ready (dma_ready),
    .rb_n      (nand_rb_n),
    .wr_data   (wr_data),
    .wr_take   (wr_take),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .io_in     (nand_io_in),
    .ale       (nand_ale),
    .cle       (nand_cle),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .io_out    (nand_io_out),
    .io_oe     (nand_io_oe),
    .done      (cmd_done),
    .irq       (cmd_irq),
    .last      (seq_last)
  );

  always_comb err_d = (cmd_push && full) || dma_err;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign cmd_err = err_q;

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_ale,
  input logic nand_cle,
  input logic nand_io_oe,
  input logic wr_take,
  input logic rd_valid,
  input logic cmd_done,
  input logic cmd_irq,
  input logic seq_last
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!nand_we_n && !nand_re_n)); // R12
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) !nand_we_n |=> nand_we_n); // R12
  AST_RE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) !nand_re_n |=> nand_re_n); // R12
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nand_ale && nand_cle)); // R3
  AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) nand_ale |-> nand_io_oe); // R2
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !nand_re_n |-> !nand_io_oe); // R5
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n) !nand_re_n |=> rd_valid); // R5
  AST_TAKE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) wr_take |-> (!nand_we_n && nand_io_oe)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cmd_done |=> !cmd_done); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cmd_done |-> (nand_we_n && nand_re_n && !nand_ale && !nand_cle)); // R7
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) cmd_irq |-> cmd_done); // R8
  AST_LAST_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) seq_last |-> cmd_done); // R9
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_ale   (nand_ale),
  .nand_cle   (nand_cle),
  .nand_io_oe (nand_io_oe),
  .wr_take    (wr_take),
  .rd_valid   (rd_valid),
  .cmd_done   (cmd_done),
  .cmd_irq    (cmd_irq),
  .seq_last   (seq_last)
);

// File: tb/nand_seq_test.sv
`timescale 1ns/1ps
module nand_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_push;
  logic [31:0] cmd_word;
  logic        dma_ready;
  logic [7:0]  wr_data;
  logic        wr_take;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        nand_ale, nand_cle, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out, nand_io_in;
  logic        nand_rb_n;
  logic        cmd_done, cmd_err, cmd_irq, seq_last;

  always #4 clk = ~clk;

  nand_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_word(cmd_word),
    .dma_ready(dma_ready), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .nand_ale(nand_ale),
    .nand_cle(nand_cle), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rb_n(nand_rb_n), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .cmd_irq(cmd_irq), .seq_last(seq_last)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int wn, rn, done_n, err_n, irq_n, last_n, re_cnt, bad_oe, done_cyc;
  logic [9:0] wlog [64];
  logic [7:0] rlog [64];
  logic [7:0] wr_idx = 8'd0, rd_src = 8'd0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (wr_take) wr_idx <= wr_idx + 8'd1;
  assign wr_data    = 8'hA0 + wr_idx;
  assign nand_io_in = 8'h50 + rd_src;

  // Event log, sampled half a cycle after each edge
  always @(negedge clk) begin
    if (!nand_we_n && wn < 64) begin
      wlog[wn] = {nand_ale, nand_cle, nand_io_out};
      wn++;
    end
    if (!nand_re_n) begin
      re_cnt++;
      if (nand_io_oe) bad_oe++;
    end
    if (rd_valid && rn < 64) begin
      rlog[rn] = rd_data;
      rn++;
      rd_src = rd_src + 8'd1;
    end
    if (cmd_done) begin
      done_n++;
      done_cyc = cyc;
      if (cmd_irq) irq_n++;
      if (seq_last) last_n++;
    end
    if (cmd_err) err_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic clr();
    wn = 0; rn = 0; done_n = 0; err_n = 0; irq_n = 0; last_n = 0;
    re_cnt = 0; bad_oe = 0; done_cyc = -1;
  endtask

  task automatic push(input logic [31:0] w, output int pc);
    cmd_push = 1'b1;
    cmd_word = w;
    tick();
    cmd_push = 1'b0;
    pc = cyc;
  endtask

  task automatic wait_done(input int n, input int lim);
    for (int i = 0; i < lim && done_n < n; i++) tick();
  endtask

  function automatic logic [31:0] mk(input int kind, input bit wfr, input bit lst,
                                     input bit iwc, input int low);
    return (32'(wfr) << 19) | (32'(lst) << 18) | (32'(kind) << 16) |
           (32'(iwc) << 13) | 32'(low);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; cmd_push = 1'b0; cmd_word = '0; dma_ready = 1'b1; nand_rb_n = 1'b1;
    repeat (3) tick();
    chk(nand_we_n && nand_re_n && !nand_ale && !nand_cle && !nand_io_oe,
        "R1 pins in reset", {nand_we_n, nand_re_n, nand_ale, nand_cle, nand_io_oe}, 5'b11000);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(!cmd_done && !cmd_err && !cmd_irq && !seq_last && nand_we_n && nand_re_n,
        "R1 idle after reset", {cmd_done, cmd_err, cmd_irq, seq_last}, 0);
  endtask

  task automatic t_addr();
    int pc;
    clr();
    push(mk(0, 0, 0, 0, 8'h3C), pc);
    wait_done(1, 40);
    chk(wn == 1, "R2 address strobe count", wn, 1);
    chk(wlog[0] == {2'b10, 8'h3C}, "R2 address pins and byte", wlog[0], {2'b10, 8'h3C});
    chk(done_cyc - pc == 3, "R7 address latency", done_cyc - pc, 3);
    chk(irq_n == 0 && last_n == 0, "R8 R9 no irq or last", irq_n + last_n, 0);
  endtask

  task automatic t_cmd();
    int pc;
    clr();
    push(mk(1, 1, 1, 1, 8'h70), pc);
    wait_done(1, 40);
    chk(wn == 1 && wlog[0] == {2'b01, 8'h70}, "R3 command pins and byte", wlog[0], {2'b01, 8'h70});
    chk(done_cyc - pc == 4, "R7 command latency with ready wait", done_cyc - pc, 4);
    chk(irq_n == 1, "R8 irq on flagged word", irq_n, 1);
    chk(last_n == 1, "R9 last on flagged word", last_n, 1);
  endtask

  task automatic t_write();
    int pc;
    logic [7:0] s;
    clr();
    s = wr_idx;
    push(mk(2, 0, 0, 0, 3), pc);
    wait_done(1, 60);
    chk(wn == 4, "R4 write strobe count", wn, 4);
    for (int k = 0; k < 4; k++)
      chk(wlog[k] == {2'b00, 8'hA0 + s + 8'(k)}, "R4 write byte", wlog[k], {2'b00, 8'hA0 + s + 8'(k)});
    chk(done_cyc - pc == 9, "R7 write latency", done_cyc - pc, 9);
  endtask

  task automatic t_read();
    int pc;
    logic [7:0] s;
    clr();
    s = rd_src;
    push(mk(3, 0, 0, 0, 2), pc);
    wait_done(1, 60);
    chk(rn == 3 && re_cnt == 3 && wn == 0, "R5 read strobe count", re_cnt, 3);
    for (int k = 0; k < 3; k++)
      chk(rlog[k] == 8'h50 + s + 8'(k), "R5 read byte", rlog[k], 8'h50 + s + 8'(k));
    chk(bad_oe == 0, "R5 bus released while reading", bad_oe, 0);
    chk(done_cyc - pc == 7, "R7 read latency", done_cyc - pc, 7);
  endtask

  task automatic t_wait();
    int pc;
    clr();
    nand_rb_n = 1'b0;
    push(mk(1, 1, 0, 0, 8'hFF), pc);
    repeat (30) tick();
    chk(done_n == 0, "R6 done held while busy", done_n, 0);
    nand_rb_n = 1'b1;
    tick();
    chk(done_n == 1, "R6 done one cycle after ready", done_n, 1);
  endtask

  task automatic t_overflow();
    int pc;
    clr();
    nand_rb_n = 1'b0;
    push(mk(1, 1, 0, 0, 8'h80), pc);
    repeat (3) tick();
    for (int k = 1; k <= 4; k++) begin
      push(mk(0, 0, 0, 0, k), pc);
      chk(!cmd_err, "R10 accepted push no error", cmd_err, 0);
    end
    push(mk(0, 0, 0, 0, 8'h99), pc);
    chk(cmd_err, "R10 error on full push", cmd_err, 1);
    nand_rb_n = 1'b1;
    wait_done(5, 100);
    repeat (10) tick();
    chk(wn == 5 && done_n == 5, "R10 dropped word not executed", wn, 5);
    chk(wlog[0][7:0] == 8'h80, "R10 order head", wlog[0][7:0], 8'h80);
    for (int k = 1; k <= 4; k++)
      chk(wlog[k] == {2'b10, 8'(k)}, "R10 push order", wlog[k], {2'b10, 8'(k)});
  endtask

  task automatic t_dma_err();
    int pc;
    clr();
    dma_ready = 1'b0;
    push(mk(2, 0, 0, 0, 0), pc);
    repeat (8) tick();
    chk(err_n == 1, "R11 error pulse", err_n, 1);
    chk(wn == 0 && re_cnt == 0, "R11 no strobe", wn + re_cnt, 0);
    chk(done_n == 0, "R11 no done", done_n, 0);
    dma_ready = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clr();
    t_reset();
    t_addr();
    t_cmd();
    t_write();
    t_read();
    t_wait();
    t_overflow();
    t_dma_err();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule